// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block is a register-mapped front end for a small one-time-programmable bit array. Software picks a cell by writing a byte address and a bit position into an address register. It then issues commands through a control register. A read command copies the chosen byte into a data register. A program command burns the chosen bit to 1. Programming is guarded in two ways: it needs an arm word followed by a fire word, and a burned bit can never return to 0.

A status register reports whether the controller is ready and whether a command has finished. A configuration register holds sticky disable and lock flags and two lock fields that contain protected bits. A read-only strap register returns, for each bit, the majority vote over three 32-bit copies kept in the first twelve bytes of the array. Each accepted command holds the controller busy for a fixed number of cycles. A command written during that time is dropped.

The array is modelled with flops. It starts blank on reset, so that simulation begins from a known state.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, STAT (word 0) reads 0x00000001, CFG (word 1) reads 0x20000000, and ADDR (word 2), DATA (word 3) and STRAP (word 5) read 0.
- R2: ADDR keeps bits [7:0] and reads all higher bits as 0. Bits [2:0] give the bit position and bits [7:3] give the byte address.
- R3: Writing 0x01 to CMD (word 4) while ready starts a read. When the read completes, DATA holds the addressed byte in bits [7:0] with zeros above it, and STAT bit 1 (read-done) and STAT bit 0 (ready) are both 1.
- R4: After an accepted command, STAT bit 0 reads 0 for exactly 4 cycles and then reads 1.
- R5: A CMD write while STAT bit 0 is 0 is ignored. It neither restarts nor lengthens the busy window, and it does not change which operation runs.
- R6: Writing 0x7F to CMD while the previous accepted CMD value is 0xBF sets the addressed bit to 1. Other bits stay unchanged, and a bit that is already 1 stays 1. A program completion also sets read-done.
- R7: Any other sequence programs nothing. This covers 0x7F without a preceding 0xBF, and 0xBF followed by any other value and then 0x7F. Such writes also leave the controller ready.
- R8: In STAT, bit 0 is read-only, bit 1 is cleared by writing 1 and kept by writing 0, bits [31:16] are freely writable, and the remaining bits read 0.
- R9: A read of CMD, or any access to words 6 or 7, raises bus_err in the same cycle and returns 0.
- R10: CFG bit 31 (disable) and bit 30 (config lock) are set by writing 1 and are cleared only by reset. Bit 29 is freely writable. Bits [7:0] (program lock) and [15:8] (read lock) are writable, except for the upper nibble of each, which is read-only, holds 0, and is kept by writes.
- R11: Each bit i of STRAP equals the majority of array bits (byte 0 to 3 copy, i), (byte 4 to 7 copy, i) and (byte 8 to 11 copy, i), with the copies little-endian. Writes to STRAP have no effect.
- R12: DATA is writable by software. Writing it does not change the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| bus_err | output | 1 | Access error for a read of CMD or an unmapped word |

## Verification
The hardest situation to reach is a command write that lands inside the busy window of an earlier command. The same applies to an arm word whose fire is broken by a stray value. Both are visible only through timing and through the unchanged array afterwards. The bench counts clock cycles from each command write. It places a second address write and a read command at fixed cycles inside the window, polls STAT every cycle to measure the window, and then reads the original byte back. Random program and read traffic from a fixed seed fills the strap copies, and a bench-side majority function checks the strap register afterwards.

// File: rtl/otp_fuse_pkg.sv
// Shared register indices, command codes and reset values for the fuse controller.
// Assumes a 32-bit register bus with a word index of three bits.
package otp_fuse_pkg;

    typedef enum logic [2:0] {
        REG_STAT  = 3'd0,
        REG_CFG   = 3'd1,
        REG_ADDR  = 3'd2,
        REG_DATA  = 3'd3,
        REG_CMD   = 3'd4,
        REG_STRAP = 3'd5
    } reg_sel_e;

    typedef enum logic {
        OP_READ = 1'b0,
        OP_PROG = 1'b1
    } op_e;

    localparam logic [31:0] CMD_READ      = 32'h0000_0001;
    localparam logic [31:0] CMD_PROG_ARM  = 32'h0000_00BF;
    localparam logic [31:0] CMD_PROG_FIRE = 32'h0000_007F;

    localparam int CFG_DIS_BIT  = 31;
    localparam int CFG_LOCK_BIT = 30;
    localparam int CFG_BIAS_BIT = 29;

    localparam int STAT_DONE_BIT = 1;

endpackage

// File: rtl/otp_bit_store.sv
// Flop model of the fuse array plus the strap majority voter.
// Programming only ORs a single bit in. Reading is combinational by byte.
// Assumes DEPTH is a power of two and at least 12, so the three strap copies fit.
module otp_bit_store #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 prog_en,
    input  logic [AW-1:0]        prog_byte,
    input  logic [2:0]           prog_bit,
    input  logic [AW-1:0]        rd_byte_addr,
    output logic [7:0]           rd_byte,
    output logic [31:0]          strap_word,
    output logic [DEPTH*8-1:0]   cells
);

    localparam int NB = DEPTH * 8;
    localparam int IW = AW + 3;

    logic [NB-1:0] cells_q;
    logic [IW-1:0] prog_idx;

    assign prog_idx = {prog_byte, prog_bit};

    // Burn one bit on a program pulse; reset stands for a blank part.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells_q <= '0;
        end else if (prog_en) begin
            cells_q[prog_idx] <= 1'b1;
        end
    end

    // Byte view for the read command.
    assign rd_byte = cells_q[{rd_byte_addr, 3'b000} +: 8];

    // Bitwise two-of-three vote across the three stored strap copies.
    for (genvar gi = 0; gi < 32; gi++) begin : g_vote
        logic c0, c1, c2;
        assign c0 = cells_q[gi];
        assign c1 = cells_q[32 + gi];
        assign c2 = cells_q[64 + gi];
        assign strap_word[gi] = (c0 & c1) | (c0 & c2) | (c1 & c2);
    end

    assign cells = cells_q;

endmodule

// File: rtl/otp_cmd_seq.sv
// Command sequencer. It decodes writes to the command register, enforces the
// arm/fire pair for programming, and runs a fixed busy window. At the end of the
// window it emits one completion pulse.
// Assumes BUSY_CYC >= 1. Writes that arrive while busy are dropped entirely.
module otp_cmd_seq
    import otp_fuse_pkg::*;
#(
    parameter int AW       = 5,
    parameter int BUSY_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [31:0]   cmd_wdata,
    input  logic [AW-1:0] sel_byte,
    input  logic [2:0]    sel_bit,
    output logic          ready,
    output logic          done,
    output logic          done_read,
    output logic          prog_en,
    output logic [AW-1:0] op_byte,
    output logic [2:0]    op_bit,
    output logic [31:0]   cmd_last
);

    localparam int CW = $clog2(BUSY_CYC + 1);

    logic [31:0]   cmd_q;
    logic          busy_q;
    logic [CW-1:0] cnt_q;
    op_e           op_q;
    logic [AW-1:0] byte_q;
    logic [2:0]    bit_q;
    logic          accept, start_rd, start_pg;

    // Decode a command write that arrives while idle.
    always_comb begin
        accept   = cmd_wr & ~busy_q;
        start_rd = accept & (cmd_wdata == CMD_READ);
        start_pg = accept & (cmd_q == CMD_PROG_ARM) & (cmd_wdata == CMD_PROG_FIRE);
    end

    // Remember the last accepted command word (the arm state lives here).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q <= cmd_wdata;
        end
    end

    // Busy window counter plus capture of the operation and its target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= OP_READ;
            byte_q <= '0;
            bit_q  <= '0;
        end else if (start_rd || start_pg) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(BUSY_CYC - 1);
            op_q   <= start_pg ? OP_PROG : OP_READ;
            byte_q <= sel_byte;
            bit_q  <= sel_bit;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign ready     = ~busy_q;
    assign done      = busy_q & (cnt_q == '0);
    assign done_read = done & (op_q == OP_READ);
    assign prog_en   = done & (op_q == OP_PROG);
    assign op_byte   = byte_q;
    assign op_bit    = bit_q;
    assign cmd_last  = cmd_q;

endmodule

// File: rtl/otp_fuse_ctrl.sv
// Top of the fuse controller. It holds the register file (status, config,
// address, data), decodes the bus, and ties the sequencer to the bit store.
// Assumes single-cycle bus accesses. Read data and the error flag are combinational.
module otp_fuse_ctrl
    import otp_fuse_pkg::*;
#(
    parameter int          DEPTH        = 32,
    parameter int          BUSY_CYC     = 4,
    parameter logic [7:0]  LOCK_RO_MASK = 8'hF0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_err
);

    localparam int AW  = $clog2(DEPTH);
    localparam int ADW = AW + 3;

    logic             wr_stat, wr_cfg, wr_addr, wr_data, wr_cmd;
    logic             unmapped, rd_cmd;
    logic             seq_ready, seq_done, seq_done_read, seq_prog;
    logic [AW-1:0]    op_byte;
    logic [2:0]       op_bit;
    logic [31:0]      cmd_last;
    logic [7:0]       rd_byte;
    logic [31:0]      strap_word;
    logic [DEPTH*8-1:0] cells;

    logic             rd_done_q;
    logic [15:0]      stat_rw_q;
    logic             cfg_dis_q, cfg_lock_q, cfg_bias_q;
    logic [7:0]       plock_q, rlock_q;
    logic [ADW-1:0]   addr_q;
    logic [31:0]      data_q;

    // Bus decode into per-register write strobes and the error conditions.
    always_comb begin
        wr_stat  = bus_req & bus_we & (bus_addr == REG_STAT);
        wr_cfg   = bus_req & bus_we & (bus_addr == REG_CFG);
        wr_addr  = bus_req & bus_we & (bus_addr == REG_ADDR);
        wr_data  = bus_req & bus_we & (bus_addr == REG_DATA);
        wr_cmd   = bus_req & bus_we & (bus_addr == REG_CMD);
        unmapped = (bus_addr > REG_STRAP);
        rd_cmd   = ~bus_we & (bus_addr == REG_CMD);
        bus_err  = bus_req & (unmapped | rd_cmd);
    end

    otp_cmd_seq #(
        .AW       (AW),
        .BUSY_CYC (BUSY_CYC)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (wr_cmd),
        .cmd_wdata (bus_wdata),
        .sel_byte  (addr_q[ADW-1:3]),
        .sel_bit   (addr_q[2:0]),
        .ready     (seq_ready),
        .done      (seq_done),
        .done_read (seq_done_read),
        .prog_en   (seq_prog),
        .op_byte   (op_byte),
        .op_bit    (op_bit),
        .cmd_last  (cmd_last)
    );

    otp_bit_store #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) i_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .prog_en      (seq_prog),
        .prog_byte    (op_byte),
        .prog_bit     (op_bit),
        .rd_byte_addr (op_byte),
        .rd_byte      (rd_byte),
        .strap_word   (strap_word),
        .cells        (cells)
    );

    // Status: read-done is set on completion (set wins) and cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_done_q <= 1'b0;
            stat_rw_q <= '0;
        end else begin
            if (seq_done) begin
                rd_done_q <= 1'b1;
            end else if (wr_stat && bus_wdata[STAT_DONE_BIT]) begin
                rd_done_q <= 1'b0;
            end
            if (wr_stat) begin
                stat_rw_q <= bus_wdata[31:16];
            end
        end
    end

    // Config: sticky disable and lock, a plain bias bit, lock fields with protected bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_dis_q  <= 1'b0;
            cfg_lock_q <= 1'b0;
            cfg_bias_q <= 1'b1;
            plock_q    <= '0;
            rlock_q    <= '0;
        end else if (wr_cfg) begin
            cfg_dis_q  <= cfg_dis_q  | bus_wdata[CFG_DIS_BIT];
            cfg_lock_q <= cfg_lock_q | bus_wdata[CFG_LOCK_BIT];
            cfg_bias_q <= bus_wdata[CFG_BIAS_BIT];
            plock_q    <= (plock_q & LOCK_RO_MASK) | (bus_wdata[7:0]  & ~LOCK_RO_MASK);
            rlock_q    <= (rlock_q & LOCK_RO_MASK) | (bus_wdata[15:8] & ~LOCK_RO_MASK);
        end
    end

    // Address register keeps only the byte and bit-position fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (wr_addr) begin
            addr_q <= bus_wdata[ADW-1:0];
        end
    end

    // Data register: loaded by a finished read (wins), otherwise software-writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (seq_done_read) begin
            data_q <= {24'd0, rd_byte};
        end else if (wr_data) begin
            data_q <= bus_wdata;
        end
    end

    // Read mux; the command register and unmapped words return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_req && !bus_we) begin
            case (bus_addr)
                REG_STAT:  bus_rdata = {stat_rw_q, 14'd0, rd_done_q, seq_ready};
                REG_CFG:   bus_rdata = {cfg_dis_q, cfg_lock_q, cfg_bias_q, 13'd0, rlock_q, plock_q};
                REG_ADDR:  bus_rdata = {{(32-ADW){1'b0}}, addr_q};
                REG_DATA:  bus_rdata = data_q;
                REG_STRAP: bus_rdata = strap_word;
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
// Property checker for the fuse controller, attached to every instance by bind.
// Assumes reset is held for at least two clock edges at start-up.
module otp_fuse_ctrl_chk #(
    parameter int NB       = 256,
    parameter int BUSY_CYC = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_we,
    input logic [2:0]    bus_addr,
    input logic [31:0]   bus_wdata,
    input logic          bus_err,
    input logic          ready,
    input logic [NB-1:0] cells,
    input logic          cfg_dis,
    input logic          cfg_lock,
    input logic [31:0]   cmd_last
);

    logic [15:0] low_cnt;
    logic        cmd_wr;

    assign cmd_wr = bus_req & bus_we & (bus_addr == 3'd4);

    // Count consecutive cycles with the ready flag low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!ready) begin
            low_cnt <= low_cnt + 16'd1;
        end else begin
            low_cnt <= '0;
        end
    end

    // R4: an accepted read command drops ready on the next cycle
    a_r4_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && ready && bus_wdata == 32'h1) |=> !ready);

    // R4: the busy window is exactly BUSY_CYC cycles long
    a_r4_window_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (low_cnt == 16'(BUSY_CYC)));

    // R5: a command written while busy leaves the command state untouched
    a_r5_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !ready) |=> $stable(cmd_last));

    // R6: burned bits never clear
    a_r6_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cells) & ~cells) == '0));

    // R6: at most one cell changes per cycle
    a_r6_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cells ^ $past(cells)) <= 1));

    // R8: a status write cannot drop the ready flag
    a_r8_ready_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == 3'd0 && ready) |=> ready);

    // R9: reading the command register is flagged
    a_r9_cmd_read_err: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr == 3'd4) |-> bus_err);

    // R10: disable and config-lock are sticky
    a_r10_dis_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_dis) |-> cfg_dis);
    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_lock) |-> cfg_lock);

endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(
    .NB       (DEPTH * 8),
    .BUSY_CYC (BUSY_CYC)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_err   (bus_err),
    .ready     (seq_ready),
    .cells     (cells),
    .cfg_dis   (cfg_dis_q),
    .cfg_lock  (cfg_lock_q),
    .cmd_last  (cmd_last)
);

// File: tb/test_otp_fuse_ctrl.sv
// Self-checking bench: directed corner cases plus seeded random program/read traffic,
// compared against a bench-side byte model of the array.
module test_otp_fuse_ctrl;

    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;

    int  total = 0;
    int  bad = 0;
    bit  ended = 0;
    logic [7:0] model [DEPTH];

    always #4 clk = ~clk;

    otp_fuse_ctrl #(.DEPTH(DEPTH), .BUSY_CYC(4), .LOCK_RO_MASK(8'hF0)) i_otp_fuse_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d, output logic e);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata; e = bus_err;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    function automatic logic [31:0] strap_exp();
        logic [31:0] a, b, c;
        a = {model[3], model[2], model[1], model[0]};
        b = {model[7], model[6], model[5], model[4]};
        c = {model[11], model[10], model[9], model[8]};
        return (a & b) | (a & c) | (b & c);
    endfunction

    task automatic do_prog(input int by, input int bi);
        wr(3'd2, 32'((by << 3) | bi));
        wr(3'd4, 32'hBF);
        wr(3'd4, 32'h7F);
        repeat (4) @(negedge clk);
        model[by] = model[by] | 8'(1 << bi);
    endtask

    task automatic read_check(input string req, input int by);
        logic [31:0] d; logic e;
        wr(3'd2, 32'(by << 3));
        wr(3'd4, 32'h1);
        repeat (4) @(negedge clk);
        rd(3'd3, d, e);
        chk(req, d, {24'd0, model[by]});
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic e;
        logic [31:0] st;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        rd(3'd0, d, e); chk("R1 stat", d, 32'h1);
        rd(3'd1, d, e); chk("R1 cfg", d, 32'h2000_0000);
        rd(3'd2, d, e); chk("R1 addr", d, 32'h0);
        rd(3'd3, d, e); chk("R1 data", d, 32'h0);
        rd(3'd5, d, e); chk("R1 strap", d, 32'h0);

        // R2: only byte and bit fields are kept
        wr(3'd2, 32'hFFFF_FF5D);
        rd(3'd2, d, e); chk("R2 addr mask", d, 32'h5D);

        // R9: command read and unmapped words flag an error
        rd(3'd4, d, e); chk("R9 cmd err", {31'd0, e}, 32'h1); chk("R9 cmd data", d, 32'h0);
        rd(3'd6, d, e); chk("R9 unmapped err", {31'd0, e}, 32'h1);
        rd(3'd0, d, e); chk("R9 no err on stat", {31'd0, e}, 32'h0);

        // R4 and R6: program one bit, measure the busy window by polling
        wr(3'd2, 32'((20 << 3) | 6));
        wr(3'd4, 32'hBF);
        wr(3'd4, 32'h7F);
        for (int k = 0; k < 4; k++) begin
            rd(3'd0, d, e); chk("R4 busy low", {31'd0, d[0]}, 32'h0);
        end
        rd(3'd0, d, e); chk("R4 ready back", {31'd0, d[0]}, 32'h1);
        chk("R6 prog sets done", {31'd0, d[1]}, 32'h1);
        model[20] = 8'h40;
        read_check("R6 bit burned", 20);
        do_prog(20, 1);
        do_prog(20, 6);
        read_check("R6 OR only", 20);

        // R3: read loads the byte and sets the done flag; R8 clear by writing 1
        wr(3'd0, 32'h2);
        rd(3'd0, d, e); chk("R8 w1c clears", d, 32'h1);
        read_check("R3 read data", 20);
        rd(3'd0, d, e); chk("R3 done and ready", d, 32'h3);
        wr(3'd0, 32'hABCD_0000);
        rd(3'd0, d, e); chk("R8 write 0 keeps done, rw bits", d, 32'hABCD_0003);
        wr(3'd0, 32'h0000_0002);
        rd(3'd0, d, e); chk("R8 ready read-only", d, 32'h0000_0001);

        // R7: fire without arm, and arm broken by another value
        wr(3'd2, 32'((5 << 3) | 3));
        wr(3'd4, 32'h7F);
        rd(3'd0, d, e); chk("R7 lone fire stays ready", {31'd0, d[0]}, 32'h1);
        wr(3'd4, 32'hBF);
        wr(3'd4, 32'h12);
        wr(3'd4, 32'h7F);
        rd(3'd0, d, e); chk("R7 broken arm stays ready", {31'd0, d[0]}, 32'h1);
        read_check("R7 array unchanged", 5);

        // R5: a second command during busy is dropped
        do_prog(9, 2);
        wr(3'd2, 32'(9 << 3));
        wr(3'd4, 32'h1);
        wr(3'd2, 32'(20 << 3));
        wr(3'd4, 32'h1);
        rd(3'd0, d, e); chk("R5 still busy", {31'd0, d[0]}, 32'h0);
        rd(3'd0, d, e); chk("R5 still busy 2", {31'd0, d[0]}, 32'h0);
        rd(3'd0, d, e); chk("R5 window not extended", {31'd0, d[0]}, 32'h1);
        rd(3'd3, d, e); chk("R5 first target read", d, {24'd0, model[9]});

        // R12: data writes do not touch the array
        wr(3'd3, 32'hDEAD_BEEF);
        rd(3'd3, d, e); chk("R12 data rw", d, 32'hDEAD_BEEF);
        read_check("R12 array intact", 9);

        // R10: sticky bits, protected lock nibbles
        wr(3'd1, 32'hC000_FFFF);
        rd(3'd1, d, e); chk("R10 set", d, 32'hC000_0F0F);
        wr(3'd1, 32'h2000_0000);
        rd(3'd1, d, e); chk("R10 sticky", d, 32'hE000_0000);

        // R11: directed strap votes then a write attempt
        do_prog(0, 5); do_prog(4, 5);
        do_prog(1, 1);
        do_prog(11, 7);
        rd(3'd5, d, e); chk("R11 strap directed", d, strap_exp());
        chk("R11 strap bit5", {31'd0, d[5]}, 32'h1);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, d, e); chk("R11 strap write ignored", d, strap_exp());

        // Boundary: last byte, top bit
        do_prog(DEPTH - 1, 7);
        read_check("R6 last byte", DEPTH - 1);

        // Random traffic from a fixed seed
        void'($urandom(32'd2024));
        for (int n = 0; n < 160; n++) begin
            int by;
            by = int'($urandom % DEPTH);
            if ($urandom % 3 != 0) begin
                if ($urandom % 2 == 0) by = int'($urandom % 12);
                do_prog(by, int'($urandom % 8));
            end else begin
                read_check("R3 random read", by);
            end
        end
        rd(3'd5, d, e); chk("R11 strap random", d, strap_exp());
        rd(3'd0, st, e); chk("R4 ready at end", {31'd0, st[0]}, 32'h1);

        finish_run();
    end

endmodule